// File: doc/BRIEF.md
# Interrupt Rate Throttling Timer

This block sits between an interrupt-request source and the host processor. It makes sure that interrupts reach the host no closer together than a programmed minimum spacing. Software writes an interval value, counted in units of 256 ns. The first request that finds the block idle goes out at once as a single-cycle pulse. After that pulse, further requests are held back until the interval has run out.

Requests that arrive while the block is holding back are not lost. They set a sticky pending condition, and one merged interrupt is issued on the exact cycle the hold-off window closes. An interval of zero turns throttling off. An internal prescaler turns the core clock into a 256 ns tick. It is restarted by every issued interrupt, so the spacing comes out as an exact number of core cycles.

Top module: `irq_throttle`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `irq_o` is low, the hold-off counter is expired and `tick_o` is low. The stored interval resets to 0.
- R2: The prescaler divides by DIV = 256000 / CLK_PERIOD_PS core cycles (at least 1). `tick_o` is high for one cycle once every DIV cycles. Counting the cycle in which `irq_o` is high as cycle 0, `tick_o` is high exactly in cycles DIV-1, 2*DIV-1, and so on.
- R3: A cycle in which `req_in` is high and the hold-off has expired makes `irq_o` high in the next cycle. Each granted interrupt is a pulse exactly one cycle wide.
- R4: After a pulse that loaded an interval N > 0, `irq_o` stays low for the following N*DIV-1 cycles.
- R5: Any number of requests that arrive during a hold-off of N > 0 produce exactly one pulse. That pulse comes in cycle N*DIV, counted from the previous pulse as cycle 0.
- R6: If a hold-off ends with no request pending, no pulse is issued. A later request then goes out in the next cycle.
- R7: With an interval of 0, every cycle with `req_in` high gives `irq_o` high in the next cycle, including back-to-back cycles.
- R8: A reload uses the interval held in the register at the clock edge that issues the pulse. A value written during a countdown does not alter the count in progress and applies from the next reload.
- R9: `ivl_wr_data` is stored on a clock edge where `ivl_wr_en` is high. On every other edge it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ivl_wr_en | input | 1 | Write strobe for the interval register |
| ivl_wr_data | input | IVL_W | Interval value in 256 ns units; 0 disables throttling |
| req_in | input | 1 | Raw interrupt request, sampled each cycle |
| tick_o | output | 1 | 256 ns clock enable from the prescaler |
| irq_o | output | 1 | Single-cycle interrupt pulse to the host |

## Verification
The checker watches these on every cycle:
- the minimum spacing between pulses, measured against the value actually loaded at each pulse;
- that no pulse appears while more than one unit of hold-off remains;
- that a request arriving at an expired counter goes out on the next cycle;
- that the counter never rises except at a reload;
- that a pending request always has a running count behind it.

Only the bench scenarios can show the rest:
- the exact cycle on which a merged interrupt appears;
- that any number of requests in a window collapse to a single pulse;
- that an interval written mid-count waits for the next reload;
- that a write without its strobe is ignored.

// File: rtl/irq_thr_pkg.sv
package irq_thr_pkg;

    // One throttle unit expressed in picoseconds.
    localparam int unsigned UNIT_PS = 256000;

    // Core cycles per throttle unit, never below one.
    function automatic int unsigned unit_div(input int unsigned period_ps);
        int unsigned d;
        d = (period_ps == 0) ? 1 : UNIT_PS / period_ps;
        return (d == 0) ? 1 : d;
    endfunction

    // Width of a counter that must hold values 0 .. n-1.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Controller state: pending requests are encoded in the state itself.
    typedef enum logic [1:0] {
        THR_IDLE  = 2'd0,  // counter expired, nothing pending
        THR_HOLD  = 2'd1,  // counting, nothing pending
        THR_ARMED = 2'd2   // counting, at least one request merged
    } thr_state_e;

    // Status the hold-off counter reports to the controller.
    typedef struct packed {
        logic idle;      // remaining count is zero
        logic expiring;  // zero now, or reaches zero at this edge
    } hold_status_t;

endpackage

// File: rtl/thr_prescaler.sv
module thr_prescaler #(
    parameter int unsigned DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    import irq_thr_pkg::*;

    localparam int unsigned CW = cnt_width(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (restart || phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = (phase_q == LAST);

endmodule

// File: rtl/thr_holdoff.sv
module thr_holdoff
    import irq_thr_pkg::*;
#(
    parameter int unsigned IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IVL_W-1:0] load_val,
    input  logic             tick,
    output hold_status_t     status,
    output logic [IVL_W-1:0] remaining
);
    localparam logic [IVL_W-1:0] ONE = IVL_W'(1);

    logic [IVL_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (tick && rem_q != '0) begin
            rem_q <= rem_q - ONE;
        end
    end

    always_comb begin
        status.idle     = (rem_q == '0);
        status.expiring = status.idle || (rem_q == ONE && tick);
    end

    assign remaining = rem_q;

endmodule

// File: rtl/thr_ctrl.sv
module thr_ctrl
    import irq_thr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  hold_status_t status,
    input  logic         load_zero,
    output logic         fire,
    output logic         irq,
    output thr_state_e   state
);
    thr_state_e state_q, state_d;
    logic       pending;

    assign pending = (state_q == THR_ARMED);
    assign fire    = status.expiring && (req || pending);

    always_comb begin
        state_d = state_q;
        if (fire) begin
            state_d = load_zero ? THR_IDLE : THR_HOLD;
        end else begin
            unique case (state_q)
                THR_IDLE:  state_d = THR_IDLE;
                THR_HOLD: begin
                    if (status.expiring) state_d = THR_IDLE;
                    else if (req)        state_d = THR_ARMED;
                end
                THR_ARMED: state_d = THR_ARMED;
                default:   state_d = THR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= THR_IDLE;
            irq     <= 1'b0;
        end else begin
            state_q <= state_d;
            irq     <= fire;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/irq_throttle.sv
module irq_throttle
    import irq_thr_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 4000,
    parameter int unsigned IVL_W         = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ivl_wr_en,
    input  logic [IVL_W-1:0] ivl_wr_data,
    input  logic             req_in,
    output logic             tick_o,
    output logic             irq_o
);
    localparam int unsigned DIV = unit_div(CLK_PERIOD_PS);

    logic [IVL_W-1:0] ivl_q;
    logic [IVL_W-1:0] remaining;
    hold_status_t     hold_st;
    thr_state_e       state;
    logic             fire;

    // Interval register: sampled by the counter only when it reloads.
    always_ff @(posedge clk) begin
        if (rst) begin
            ivl_q <= '0;
        end else if (ivl_wr_en) begin
            ivl_q <= ivl_wr_data;
        end
    end

    thr_prescaler #(.DIV(DIV)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (fire),
        .tick    (tick_o)
    );

    thr_holdoff #(.IVL_W(IVL_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .load      (fire),
        .load_val  (ivl_q),
        .tick      (tick_o),
        .status    (hold_st),
        .remaining (remaining)
    );

    thr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (req_in),
        .status    (hold_st),
        .load_zero (ivl_q == '0),
        .fire      (fire),
        .irq       (irq_o),
        .state     (state)
    );

endmodule

// File: rtl/irq_throttle_chk.sv
module irq_throttle_chk
    import irq_thr_pkg::*;
#(
    parameter int unsigned IVL_W = 16,
    parameter int unsigned DIV   = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             req_in,
    input logic             irq_o,
    input logic             tick_o,
    input logic [IVL_W-1:0] ivl_q,
    input logic [IVL_W-1:0] remaining,
    input thr_state_e       state
);
    logic              seen_q;
    int unsigned       since_q;
    logic [IVL_W-1:0]  need_q;

    // Cycles since the last pulse and the interval that pulse loaded.
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= 1'b0;
            since_q <= 0;
            need_q  <= '0;
        end else if (irq_o) begin
            seen_q  <= 1'b1;
            since_q <= 1;
            need_q  <= remaining;
        end else if (since_q != 32'hFFFF_FFFF) begin
            since_q <= since_q + 1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_o && remaining == '0));

    assert_tick_phase_R2: assert property (@(posedge clk) disable iff (rst)
        (DIV > 1) && irq_o |-> !tick_o);

    assert_idle_grant_R3: assert property (@(posedge clk) disable iff (rst)
        req_in && remaining == '0 |=> irq_o);

    assert_holdoff_R4: assert property (@(posedge clk) disable iff (rst)
        remaining > IVL_W'(1) |=> !irq_o);

    assert_min_gap_R4: assert property (@(posedge clk) disable iff (rst)
        irq_o && seen_q |-> since_q >= (int'(need_q) * int'(DIV)));

    assert_pending_counts_R5: assert property (@(posedge clk) disable iff (rst)
        state == THR_ARMED |-> remaining != '0);

    assert_zero_passthru_R7: assert property (@(posedge clk) disable iff (rst)
        irq_o && $past(ivl_q) == '0 |-> remaining == '0);

    assert_no_midcount_jump_R8: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> remaining <= $past(remaining));

endmodule

bind irq_throttle irq_throttle_chk #(.IVL_W(IVL_W), .DIV(DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_in    (req_in),
    .irq_o     (irq_o),
    .tick_o    (tick_o),
    .ivl_q     (ivl_q),
    .remaining (remaining),
    .state     (state)
);

// File: tb/irq_throttle_tb.sv
module irq_throttle_tb;
    localparam int CLK_T  = 10;
    localparam int PER_PS = 64000;
    localparam int DIV    = 4;
    localparam int W      = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         req = 1'b0;
    logic         tick;
    logic         irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_T/2) clk = ~clk;

    irq_throttle #(.CLK_PERIOD_PS(PER_PS), .IVL_W(W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .ivl_wr_en   (wr_en),
        .ivl_wr_data (wr_data),
        .req_in      (req),
        .tick_o      (tick),
        .irq_o       (irq)
    );

    task automatic check(input bit ok, input string rid, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rid, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_ivl(input int v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = W'(v);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic idle_wait(input int cyc, output int irqs, output int ticks);
        @(negedge clk);
        req = 1'b0;
        irqs = 0;
        ticks = 0;
        for (int k = 0; k < cyc; k++) begin
            step();
            if (irq)  irqs++;
            if (tick) ticks++;
        end
    endtask

    // Request at an expired counter; req stays high on return.
    task automatic fire_one(input string rid);
        @(negedge clk);
        req = 1'b1;
        step();
        check(irq === 1'b1, rid, int'(irq), 1);
    endtask

    task automatic gap_meas(input int limit, input bit chk_tick, output int gap, output int tick_err);
        gap = -1;
        tick_err = 0;
        for (int j = 1; j <= limit; j++) begin
            step();
            if (irq) begin
                gap = j;
                break;
            end
            if (chk_tick && (tick !== ((j % DIV) == DIV - 1))) tick_err++;
        end
    endtask

    initial begin
        #(CLK_T * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int g, te, ci, ct, cnt, pos;

        // R1: reset state
        repeat (3) step();
        check(irq === 1'b0, "R1 irq in reset", int'(irq), 0);
        @(negedge clk);
        rst = 1'b0;
        step();
        check(irq === 1'b0, "R1 irq after reset", int'(irq), 0);
        check(tick === 1'b0, "R1 tick after reset", int'(tick), 0);

        // R1/R9: reset interval is 0, so back-to-back requests both pass
        fire_one("R1 first request");
        step();
        check(irq === 1'b1, "R9 reset interval zero", int'(irq), 1);
        @(negedge clk);
        req = 1'b0;
        step();
        check(irq === 1'b0, "R3 pulse ends", int'(irq), 0);

        // Sweep of intervals 0..6
        for (int n = 0; n <= 6; n++) begin
            idle_wait(40, ci, ct);
            check(ci == 0, "R6 quiet while idle", ci, 0);
            check(ct == 40 / DIV, "R2 free tick rate", ct, 40 / DIV);
            write_ivl(n);
            fire_one("R3 grant at expired counter");
            gap_meas(n * DIV + 10, n > 0, g, te);
            check(g == ((n == 0) ? 1 : n * DIV), (n == 0) ? "R7 zero interval" : "R4 spacing", g,
                  (n == 0) ? 1 : n * DIV);
            if (n > 0) check(te == 0, "R2 tick phase after pulse", te, 0);
            gap_meas(n * DIV + 10, 1'b0, g, te);
            check(g == ((n == 0) ? 1 : n * DIV), "R5 held request merged", g,
                  (n == 0) ? 1 : n * DIV);
            @(negedge clk);
            req = 1'b0;
            step();
            check(irq === 1'b0, "R3 single-cycle pulse", int'(irq), 0);
            idle_wait(2 * n * DIV + 8, ci, ct);
            check(ci == 0, "R6 no pulse without pending", ci, 0);
            fire_one("R6 request after expiry");
            @(negedge clk);
            req = 1'b0;
        end

        // R5: scattered requests inside one window give one pulse at N*DIV
        idle_wait(40, ci, ct);
        write_ivl(3);
        fire_one("R3 merge start");
        @(negedge clk);
        req = 1'b0;
        cnt = 0;
        pos = -1;
        for (int j = 1; j <= 40; j++) begin
            step();
            if (irq) begin
                cnt++;
                if (pos < 0) pos = j;
            end
            @(negedge clk);
            req = (j == 2 || j == 5 || j == 7);
        end
        check(cnt == 1, "R5 merged count", cnt, 1);
        check(pos == 3 * DIV, "R5 merged position", pos, 3 * DIV);

        // R8/R9: write during countdown applies at next reload only
        idle_wait(40, ci, ct);
        write_ivl(5);
        fire_one("R3 reload start");
        g = -1;
        for (int j = 1; j <= 40; j++) begin
            step();
            if (irq) begin
                g = j;
                break;
            end
            if (j == 2) begin
                @(negedge clk);
                wr_en   = 1'b1;
                wr_data = W'(2);
            end else if (j == 3) begin
                @(negedge clk);
                wr_en   = 1'b0;
                wr_data = W'(9);
            end
        end
        check(g == 5 * DIV, "R8 running count kept", g, 5 * DIV);
        gap_meas(30, 1'b0, g, te);
        check(g == 2 * DIV, "R8 new value at reload", g, 2 * DIV);
        gap_meas(30, 1'b0, g, te);
        check(g == 2 * DIV, "R9 data without strobe ignored", g, 2 * DIV);
        @(negedge clk);
        req = 1'b0;
        wr_data = '0;
        idle_wait(20, ci, ct);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule